// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from reset to a usable state. After reset is released it holds the command bus idle for a programmable power-up interval. It then closes all banks with a precharge, runs a programmable number of auto-refresh cycles, and loads the mode register. Once a final settle interval has elapsed it raises a done flag. The rest of the memory controller watches that flag before it takes over the command bus.

Every interval is a cycle count set by a parameter, so one build fits any clock frequency. The command pins and address are registered. Each command occupies exactly one cycle, and every other cycle carries a no-operation. The mode word requests bursts of four in sequential order, with a CAS latency of 2 or 3 taken from a parameter, and burst writes.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first command, the outputs show NOP with addr_o = 0 and done_o = 0.
- R2: Counting rising edges from reset release as 1, 2, ..., the precharge-all command appears after edge PWR_UP_CYC, with addr_o = 13'h400 (bit 10 set).
- R3: N_REF auto-refresh commands follow. The first appears T_RP_CYC edges after the precharge, the others T_RC_CYC edges apart, each with addr_o = 0.
- R4: The mode-register load appears T_RC_CYC edges after the last refresh. Its addr_o carries burst length 4 in bits [2:0] = 3'b010, sequential order in bit 3 = 0, CAS_LAT in bits [6:4], burst writes in bit 9 = 0, and zero in all other bits.
- R5: done_o rises T_MRD_CYC edges after the mode-register load and stays high until reset.
- R6: Every cycle that carries no command, including every cycle after done, shows NOP with addr_o = 0.
- R7: Encodings on {cs_no, ras_no, cas_no, we_no} are NOP = 0111, precharge = 0010, auto-refresh = 0001 and mode load = 0000. No other value appears.
- R8: Asserting rst_ni at any point clears done_o and the bus at once. Releasing it restarts the whole sequence from the power-up wait.
- R9: bank_o is 0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | 13 | Multiplexed address / mode word |
| bank_o | output | 2 | Bank select |
| done_o | output | 1 | Sticky initialization-complete flag |

## Verification
Each result is due on a fixed rising edge counted from reset release. The precharge is due at edge PWR_UP_CYC, and every later command is due at the previous command's edge plus its gap. done_o is due at the mode load edge plus T_MRD_CYC. Each output lands one register after its edge. The bench therefore counts edges itself and compares every output at the following falling edge against the expected value for that edge index, so the exact cycle of each command is checked and not just the order. Resets are dropped in at random edges and at directed edges (just after the precharge, one edge before done). The checks confirm that the outputs clear within the same cycle and that the edge count restarts from one.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int A_ALLBANK = 10;

  typedef enum logic [2:0] {ST_PRE, ST_REF, ST_MRS, ST_FIN, ST_DONE} seq_st_e;
  typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_MRS} op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  function automatic pins_t op_pins(op_e op);
    case (op)
      OP_PRE:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_REF:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      OP_MRS:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: return PINS_NOP;
    endcase
  endfunction

  // burst 4, sequential, burst writes, CL in [6:4]
  function automatic logic [ADDR_W-1:0] mode_word(int unsigned cl);
    logic [ADDR_W-1:0] w;
    w      = '0;
    w[2:0] = 3'b010;
    w[3]   = 1'b0;
    w[6:4] = cl[2:0];
    w[9]   = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/init_cmd_drv.sv
module init_cmd_drv
  import sdram_init_pkg::*;
#(
  parameter int CAS_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  op_e               op_i,
  output pins_t             pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    if (fire_i) begin
      case (op_i)
        OP_PRE:  addr_d[A_ALLBANK] = 1'b1;
        OP_MRS:  addr_d = mode_word(CAS_LAT);
        default: addr_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= PINS_NOP;
      addr_o <= '0;
      bank_o <= '0;
    end else begin
      pins_o <= fire_i ? op_pins(op_i) : PINS_NOP;
      addr_o <= addr_d;
      bank_o <= '0;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWR_UP_CYC = 25000,
  parameter int T_RP_CYC   = 5,
  parameter int T_RC_CYC   = 16,
  parameter int T_MRD_CYC  = 2,
  parameter int N_REF      = 2,
  parameter int CAS_LAT    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        cs_no,
  output logic        ras_no,
  output logic        cas_no,
  output logic        we_no,
  output logic [12:0] addr_o,
  output logic [1:0]  bank_o,
  output logic        done_o
);
  localparam int MAX_A = (PWR_UP_CYC > T_RC_CYC) ? PWR_UP_CYC : T_RC_CYC;
  localparam int MAX_B = (T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam int RW    = $clog2(N_REF + 1);

  seq_st_e       st_q;
  logic [RW-1:0] ref_q;
  logic          done_q;
  logic          tmr_zero;
  logic          fire;
  logic [TW-1:0] gap_d;
  op_e           op;
  pins_t         pins;

  assign fire = tmr_zero && (st_q != ST_DONE);

  always_comb begin
    op    = OP_NOP;
    gap_d = '0;
    case (st_q)
      ST_PRE: begin op = OP_PRE; gap_d = TW'(T_RP_CYC - 1);  end
      ST_REF: begin op = OP_REF; gap_d = TW'(T_RC_CYC - 1);  end
      ST_MRS: begin op = OP_MRS; gap_d = TW'(T_MRD_CYC - 1); end
      default: begin op = OP_NOP; gap_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PRE;
      ref_q  <= '0;
      done_q <= 1'b0;
    end else if (fire) begin
      case (st_q)
        ST_PRE: st_q <= ST_REF;
        ST_REF: begin
          ref_q <= ref_q + 1'b1;
          if (ref_q == RW'(N_REF - 1)) st_q <= ST_MRS;
        end
        ST_MRS: st_q <= ST_FIN;
        ST_FIN: begin
          st_q   <= ST_DONE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  init_timer #(
    .W       (TW),
    .RST_VAL (PWR_UP_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire),
    .load_val_i (gap_d),
    .zero_o     (tmr_zero)
  );

  init_cmd_drv #(
    .CAS_LAT (CAS_LAT)
  ) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .op_i   (op),
    .pins_o (pins),
    .addr_o (addr_o),
    .bank_o (bank_o)
  );

  assign cs_no  = pins.cs_n;
  assign ras_no = pins.ras_n;
  assign cas_no = pins.cas_n;
  assign we_no  = pins.we_n;
  assign done_o = done_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int N_REF   = 2,
  parameter int CAS_LAT = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_no,
  input logic        ras_no,
  input logic        cas_no,
  input logic        we_no,
  input logic [12:0] addr_o,
  input logic [1:0]  bank_o,
  input logic        done_o
);
  logic [3:0]  cmd;
  logic        pre_seen;
  logic        mrs_seen;
  logic [7:0]  ref_seen;
  logic [12:0] exp_mode;

  assign cmd      = {cs_no, ras_no, cas_no, we_no};
  assign exp_mode = 13'((CAS_LAT << 4) | 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_seen <= 1'b0;
      mrs_seen <= 1'b0;
      ref_seen <= '0;
    end else begin
      if (cmd == 4'b0010) pre_seen <= 1'b1;
      if (cmd == 4'b0001) ref_seen <= ref_seen + 1'b1;
      if (cmd == 4'b0000) mrs_seen <= 1'b1;
    end
  end

  assert_done_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_done_after_mrs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> mrs_seen);
  assert_idle_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd == 4'b0111 && addr_o == '0));
  assert_pre_allbank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> addr_o[10]);
  assert_ref_after_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0001) |-> (pre_seen && !mrs_seen));
  assert_mrs_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> (ref_seen == 8'(N_REF) && addr_o == exp_mode));
  assert_legal_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});
  assert_bank_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_o == '0);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .N_REF   (N_REF),
  .CAS_LAT (CAS_LAT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .we_no  (we_no),
  .addr_o (addr_o),
  .bank_o (bank_o),
  .done_o (done_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int P    = 40;
  localparam int TRP  = 3;
  localparam int TRC  = 7;
  localparam int TMRD = 2;
  localparam int NR   = 2;
  localparam int CL   = 3;
  localparam int T_MRS  = P + TRP + NR * TRC;
  localparam int T_DONE = T_MRS + TMRD;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_no, ras_no, cas_no, we_no, done_o;
  logic [12:0] addr_o;
  logic [1:0]  bank_o;

  int n_run = 0;
  int n_fail = 0;
  int k = 0;
  bit restarted = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_init_seq #(
    .PWR_UP_CYC (P), .T_RP_CYC (TRP), .T_RC_CYC (TRC),
    .T_MRD_CYC (TMRD), .N_REF (NR), .CAS_LAT (CL)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .cs_no (cs_no), .ras_no (ras_no), .cas_no (cas_no), .we_no (we_no),
    .addr_o (addr_o), .bank_o (bank_o), .done_o (done_o)
  );

  function automatic logic [3:0] exp_cmd(int e);
    if (e == P) return 4'b0010;
    for (int i = 0; i < NR; i++) if (e == P + TRP + i * TRC) return 4'b0001;
    if (e == T_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [12:0] exp_addr(int e);
    if (e == P) return 13'h400;
    if (e == T_MRS) return 13'((CL << 4) | 2);
    return 13'h0;
  endfunction

  function automatic string req_of(int e);
    logic [3:0] c = exp_cmd(e);
    if (e == 0) return "R1";
    case (c)
      4'b0010: return "R2/R7";
      4'b0001: return "R3/R7";
      4'b0000: return "R4/R7";
      default: return (e < P) ? "R1/R6" : "R6";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv, string what);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s%s %s at edge %0d: actual %0h expected %0h",
               req, restarted ? " R8" : "", what, k, act, expv);
    end
  endtask

  task automatic check_all();
    check(req_of(k), 32'({cs_no, ras_no, cas_no, we_no}), 32'(exp_cmd(k)), "cmd");
    check(req_of(k), 32'(addr_o), 32'(exp_addr(k)), "addr");
    check("R9", 32'(bank_o), 32'd0, "bank");
    check("R5", 32'(done_o), 32'(k >= T_DONE), "done");
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #0.5;
    k = 0;
    check_all();  // R8 async clear
    repeat (2) @(negedge clk);
    check_all();  // R1 held in reset
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    k = 0;
    check_all();  // R1
    rst_ni = 1'b1;
    run(T_DONE + 20);  // full sequence, done sticky R5
    restarted = 1'b1;
    do_reset(); run(P);           // reset right after precharge
    do_reset(); run(T_DONE - 1);  // reset one edge before done
    do_reset(); run(T_DONE + 5);
    for (int t = 0; t < 10; t++) begin
      do_reset();
      run(int'($urandom_range(1, T_DONE + 10)));
    end
    do_reset(); run(T_DONE + 8);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired at edge %0d: actual hung expected finished", k);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule